// File: doc/BRIEF.md
# DDR2 Clock-Ratio Change Sequencer

This block changes the ratio between the controller clock and the DRAM clock of a DDR2 interface without losing the memory contents. A requester offers a new divider value over a valid/ready handshake. The value is checked against a programmable lower and upper bound. A value outside the bounds is refused with a one-cycle error pulse, and the block stays idle.

An accepted value starts a fixed sequence. On-die termination is switched off first. The DRAM then enters precharge power-down with CKE low. A one-cycle strobe hands the new divider to the clock generator, and the block waits until that generator reports a stable clock. A guard period of DDR clock ticks follows. CKE is then raised, and a DLL-reset mode-register command is sent. The block waits for the DLL lock indication, guarded by a timeout. If the configuration asks for it, a second mode-register command follows to reprogram latencies for the new frequency.

The last step restores termination to its configured enable and pulses done. Mode-register commands, the clock generator and the DLL are reached through simple request/acknowledge or level signals.

Top module: `clkratio_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request with `div_min <= req_div <= div_max` that is taken while ready makes `busy` high from the next cycle until the cycle after `done`.
- R2: A request taken while ready with `req_div` below `div_min` or above `div_max` gives `err` high for exactly one cycle, in the next cycle. `busy` stays low, no divider strobe occurs, `cke` stays high and `odt` keeps its configured value.
- R3: After acceptance, `odt` goes low one cycle before `cke` goes low. Nothing else in the sequence happens before `odt` is off.
- R4: `div_update` pulses for one cycle, with `cke` and `odt` both low, and `div_value` then equals the accepted divider.
- R5: `cke` returns high only after `clk_stable` is high and at least `GUARD_TICKS` (default 2) `ddr_tick` pulses have been counted in power-down after the clock became stable.
- R6: Each mode-register command holds `mrs_req` high, with `mrs_sel` unchanged, until `mrs_ack`. Such commands are issued only while `cke` is high and `odt` is low. The DLL reset (`mrs_sel` = 0) comes first.
- R7: `odt` stays low from the cycle after acceptance until the done cycle, including the whole wait for `dll_locked`.
- R8: The extra command (`mrs_sel` = 1) is sent after lock only when `extra_mrs_en` was high at acceptance. Otherwise done follows lock directly.
- R9: `done` is a one-cycle pulse. In that cycle `odt` equals `odt_en_cfg`, and `busy` is low in the next cycle.
- R10: If `dll_locked` is not seen within `LOCK_TIMEOUT`+1 cycles after the DLL-reset acknowledge, the block pulses `err`, does not pulse `done`, and returns to idle with `cke` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Change request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_div | input | DIV_W | Requested divider |
| div_min | input | DIV_W | Lowest legal divider |
| div_max | input | DIV_W | Highest legal divider |
| extra_mrs_en | input | 1 | Send the extra mode-register command after lock |
| odt_en_cfg | input | 1 | Termination enable used outside the sequence |
| ddr_tick | input | 1 | One pulse per DDR clock cycle |
| clk_stable | input | 1 | New clock reported stable |
| dll_locked | input | 1 | DLL lock indication |
| mrs_ack | input | 1 | Mode-register command accepted |
| odt | output | 1 | Termination enable to DRAM |
| cke | output | 1 | Clock enable to DRAM |
| div_update | output | 1 | One-cycle strobe to load the new divider |
| div_value | output | DIV_W | Divider presented with the strobe |
| mrs_req | output | 1 | Mode-register command request |
| mrs_sel | output | 1 | 0 = DLL reset, 1 = extra reprogramming command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for rejection or lock timeout |

## Verification
The bench tries dividers exactly on both bounds and one step outside each. A design with an off-by-one compare would either refuse a legal edge value or start a sequence, with a divider strobe, for an illegal one. It runs sequences with the extra command on and off and with termination configured on and off. A design that skipped, duplicated or reordered a command, or that restored termination early, would produce an event stream that does not match the expected one. A DLL that never locks tests the timeout: a design without it would hang busy, and one that pulsed done anyway would show an unexpected done. The power-down exit is compared against the count of DDR ticks seen after the clock became stable, which exposes a missing or short guard period.

// File: rtl/clkratio_pkg.sv
// Shared types for the clock-ratio change sequencer.
// Assumes: one state register, Moore-style outputs decoded from it.
package clkratio_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ODT_OFF,
        ST_PD_ENTER,
        ST_DIV_SET,
        ST_WAIT_CLK,
        ST_GUARD,
        ST_PD_EXIT,
        ST_DLL_RST,
        ST_WAIT_LOCK,
        ST_EXTRA_MRS,
        ST_FINISH
    } seq_state_e;

    localparam logic MRS_DLL_RESET = 1'b0;
    localparam logic MRS_REPROGRAM = 1'b1;

endpackage

// File: rtl/cr_range_check.sv
// Inclusive bound check of a divider value.
// Assumes: lo <= hi is the caller's concern; unsigned compare.
module cr_range_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         in_range
);

    // Value is legal when it lies on or between both bounds.
    always_comb in_range = (value >= lo) && (value <= hi);

endmodule

// File: rtl/cr_down_counter.sv
// Loadable down-counter that saturates at zero.
// Assumes: load has priority over decrement.
module cr_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);

    logic [W-1:0] cnt_q;

    // Load a fresh window or count down one step per enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Flag the expired window.
    always_comb is_zero = (cnt_q == '0);

endmodule

// File: rtl/clkratio_seq.sv
// Clock-ratio change sequencer for a DDR2 controller.
// Orders termination-off, power-down entry, divider strobe, clock-stable
// wait, tick guard, power-down exit, DLL reset, lock wait with timeout and
// an optional reprogramming command. Assumes ddr_tick is a one-cycle pulse
// per DDR clock, and that mrs_ack is a pulse answering a held mrs_req.
module clkratio_seq
    import clkratio_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int GUARD_TICKS  = 2,
    parameter int LOCK_TIMEOUT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [DIV_W-1:0] req_div,
    input  logic [DIV_W-1:0] div_min,
    input  logic [DIV_W-1:0] div_max,
    input  logic             extra_mrs_en,
    input  logic             odt_en_cfg,
    input  logic             ddr_tick,
    input  logic             clk_stable,
    input  logic             dll_locked,
    input  logic             mrs_ack,
    output logic             odt,
    output logic             cke,
    output logic             div_update,
    output logic [DIV_W-1:0] div_value,
    output logic             mrs_req,
    output logic             mrs_sel,
    output logic             busy,
    output logic             done,
    output logic             err
);

    localparam int CNT_MAX = (GUARD_TICKS > LOCK_TIMEOUT) ? GUARD_TICKS : LOCK_TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic             extra_q;
    logic             err_q;
    logic             in_range;
    logic             accept, reject;
    logic             guard_zero, tmo_zero;
    logic             lock_fail;

    cr_range_check #(.W(DIV_W)) u_range (
        .value    (req_div),
        .lo       (div_min),
        .hi       (div_max),
        .in_range (in_range)
    );

    cr_down_counter #(.W(CNT_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state_q == ST_WAIT_CLK) && clk_stable),
        .load_val (CNT_W'(GUARD_TICKS)),
        .dec      ((state_q == ST_GUARD) && ddr_tick),
        .is_zero  (guard_zero)
    );

    cr_down_counter #(.W(CNT_W)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state_q == ST_DLL_RST) && mrs_ack),
        .load_val (CNT_W'(LOCK_TIMEOUT)),
        .dec      (state_q == ST_WAIT_LOCK),
        .is_zero  (tmo_zero)
    );

    // Classify an offered request while idle.
    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid && in_range;
        reject    = (state_q == ST_IDLE) && req_valid && !in_range;
        lock_fail = (state_q == ST_WAIT_LOCK) && !dll_locked && tmo_zero;
    end

    // Next-state selection for the fixed ordering.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_ODT_OFF;
            ST_ODT_OFF:   state_d = ST_PD_ENTER;
            ST_PD_ENTER:  state_d = ST_DIV_SET;
            ST_DIV_SET:   state_d = ST_WAIT_CLK;
            ST_WAIT_CLK:  if (clk_stable) state_d = ST_GUARD;
            ST_GUARD:     if (guard_zero) state_d = ST_PD_EXIT;
            ST_PD_EXIT:   state_d = ST_DLL_RST;
            ST_DLL_RST:   if (mrs_ack) state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (dll_locked)
                    state_d = extra_q ? ST_EXTRA_MRS : ST_FINISH;
                else if (tmo_zero)
                    state_d = ST_IDLE;
            end
            ST_EXTRA_MRS: if (mrs_ack) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State, latched request fields and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
            extra_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= reject || lock_fail;
            if (accept) begin
                div_q   <= req_div;
                extra_q <= extra_mrs_en;
            end
        end
    end

    // Decode the DRAM-side controls from the current state.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
        odt        = ((state_q == ST_IDLE) || (state_q == ST_FINISH)) ? odt_en_cfg : 1'b0;
        cke        = !((state_q == ST_PD_ENTER) || (state_q == ST_DIV_SET) ||
                       (state_q == ST_WAIT_CLK) || (state_q == ST_GUARD));
        div_update = (state_q == ST_DIV_SET);
        div_value  = div_q;
        mrs_req    = (state_q == ST_DLL_RST) || (state_q == ST_EXTRA_MRS);
        mrs_sel    = (state_q == ST_EXTRA_MRS) ? MRS_REPROGRAM : MRS_DLL_RESET;
        done       = (state_q == ST_FINISH);
        err        = err_q;
    end

endmodule

// File: rtl/clkratio_seq_chk.sv
// Port-level protocol checker for clkratio_seq, attached by bind.
// Assumes: clk_stable is held high once reported until the next divider strobe.
module clkratio_seq_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [DIV_W-1:0] req_div,
    input logic [DIV_W-1:0] div_min,
    input logic [DIV_W-1:0] div_max,
    input logic             clk_stable,
    input logic             mrs_ack,
    input logic             odt,
    input logic             cke,
    input logic             div_update,
    input logic             mrs_req,
    input logic             mrs_sel,
    input logic             busy,
    input logic             done,
    input logic             err
);

    a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_div >= div_min && req_div <= div_max) |=> busy);

    a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_div < div_min || req_div > div_max)) |=> (err && !busy));

    a_r3_odt_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!odt));

    a_r4_strobe_in_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
        div_update |-> (!cke && !odt));

    a_r5_exit_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(cke)) |-> clk_stable);

    a_r6_mrs_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_req |-> (cke && !odt));

    a_r6_mrs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_req && !mrs_ack) |=> (mrs_req && $stable(mrs_sel)));

    a_r7_odt_off_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> !odt);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r10_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

bind clkratio_seq clkratio_seq_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_div    (req_div),
    .div_min    (div_min),
    .div_max    (div_max),
    .clk_stable (clk_stable),
    .mrs_ack    (mrs_ack),
    .odt        (odt),
    .cke        (cke),
    .div_update (div_update),
    .mrs_req    (mrs_req),
    .mrs_sel    (mrs_sel),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/clkratio_seq_bench.sv
// Scoreboard bench: the driver queues the expected event stream and a
// negedge monitor turns port activity into events and compares them.
module clkratio_seq_bench;

    localparam int CLK_PERIOD   = 10;
    localparam int DIV_W        = 8;
    localparam int GUARD_TICKS  = 2;
    localparam int LOCK_TIMEOUT = 64;
    localparam int WATCHDOG     = 20000;
    localparam int ACK_DLY      = 2;
    localparam int STABLE_DLY   = 5;

    localparam int EV_ODT_OFF = 1;
    localparam int EV_CKE_LO  = 2;
    localparam int EV_DIV     = 3;
    localparam int EV_CKE_HI  = 4;
    localparam int EV_MRS     = 5;
    localparam int EV_DONE    = 6;
    localparam int EV_ERR     = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [DIV_W-1:0] req_div = '0, div_min = 8'd2, div_max = 8'd8;
    logic extra_mrs_en = 1'b0, odt_en_cfg = 1'b1;
    logic ddr_tick = 1'b0, clk_stable = 1'b1, dll_locked = 1'b0, mrs_ack = 1'b0;
    logic odt, cke, div_update, mrs_req, mrs_sel, busy, done, err;
    logic [DIV_W-1:0] div_value;

    int checks = 0, errors = 0;
    int exp_q[$];
    int lock_delay = 10;
    int lock_cnt = -1, ack_cnt = 0, stab_cnt = 0, tick_cnt = 0, odt_viol = 0;
    logic prev_odt = 1'b1, prev_cke = 1'b1, prev_mrs = 1'b0, prev_done = 1'b0;

    clkratio_seq #(.DIV_W(DIV_W), .GUARD_TICKS(GUARD_TICKS), .LOCK_TIMEOUT(LOCK_TIMEOUT)) u_clkratio_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_div(req_div), .div_min(div_min), .div_max(div_max),
        .extra_mrs_en(extra_mrs_en), .odt_en_cfg(odt_en_cfg), .ddr_tick(ddr_tick),
        .clk_stable(clk_stable), .dll_locked(dll_locked), .mrs_ack(mrs_ack),
        .odt(odt), .cke(cke), .div_update(div_update), .div_value(div_value),
        .mrs_req(mrs_req), .mrs_sel(mrs_sel), .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sb_compare(input int ev, input int data, input string tag);
        int got = ev * 256 + data;
        if (exp_q.size() == 0) begin
            check(1'b0, {tag, " unexpected event"}, got, -1);
        end else begin
            int want = exp_q.pop_front();
            check(got == want, tag, got, want);
        end
    endtask

    // Device-side models: DDR tick, clock generator, mode-register port, DLL.
    always @(negedge clk) begin
        ddr_tick <= ~ddr_tick;
        if (div_update) begin
            clk_stable <= 1'b0; stab_cnt = STABLE_DLY; dll_locked <= 1'b0;
        end else if (stab_cnt > 0) begin
            stab_cnt--;
            if (stab_cnt == 0) clk_stable <= 1'b1;
        end
        if (mrs_ack) begin
            mrs_ack <= 1'b0;
            if (!mrs_sel) lock_cnt = lock_delay;
        end else if (mrs_req) begin
            if (ack_cnt == ACK_DLY) begin mrs_ack <= 1'b1; ack_cnt = 0; end
            else ack_cnt++;
        end
        if (lock_cnt > 0) lock_cnt--;
        else if (lock_cnt == 0) begin dll_locked <= 1'b1; lock_cnt = -1; end
    end

    // Count DDR ticks seen in power-down once the new clock is stable (R5).
    always @(posedge clk) begin
        if (div_update) tick_cnt = 0;
        else if (busy && clk_stable && !cke && ddr_tick) tick_cnt++;
    end

    // Monitor: turn port activity into events and compare with the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && req_ready) check(1'b0, "R1 ready while busy", 1, 0);
            if (busy && !done && odt) odt_viol++;
            if (prev_odt && !odt && busy) sb_compare(EV_ODT_OFF, 0, "R3 odt off");
            if (prev_cke && !cke) begin
                check(!prev_odt, "R3 odt low before cke", prev_odt, 0);
                sb_compare(EV_CKE_LO, 0, "R3 cke low");
            end
            if (div_update) sb_compare(EV_DIV, int'(div_value), "R4 divider strobe");
            if (!prev_cke && cke && busy) begin
                check(tick_cnt >= GUARD_TICKS && clk_stable, "R5 guard before exit", tick_cnt, GUARD_TICKS);
                sb_compare(EV_CKE_HI, 0, "R5 cke high");
            end
            if (mrs_req && !prev_mrs) begin
                check(cke && !odt, "R6 mrs with cke high", {cke, odt}, 2);
                sb_compare(EV_MRS, int'(mrs_sel), "R6/R8 mrs command");
            end
            if (done) begin
                check(odt == odt_en_cfg, "R9 odt restored", odt, odt_en_cfg);
                sb_compare(EV_DONE, 0, "R9 done");
            end
            if (prev_done) check(!busy, "R9 busy drops", busy, 0);
            if (err) sb_compare(EV_ERR, 0, "R2/R10 err pulse");
        end
        prev_odt = odt; prev_cke = cke; prev_mrs = mrs_req; prev_done = done;
    end

    task automatic offer(input logic [DIV_W-1:0] d);
        @(negedge clk); #1;
        req_div = d; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic settle(input string tag);
        int n = 0;
        while ((busy || exp_q.size() != 0) && n < 500) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        #1;
        check(exp_q.size() == 0, {tag, " expected events seen"}, exp_q.size(), 0);
        check(!busy && cke, {tag, " idle with cke high"}, {busy, cke}, 1);
        check(odt_viol == 0, "R7 odt off through sequence", odt_viol, 0);
        exp_q.delete();
        odt_viol = 0;
    endtask

    // Driver: queue the expected stream for one change, then offer it.
    task automatic run_change(input logic [DIV_W-1:0] d, input bit extra, input bit ocfg, input int ldly);
        odt_en_cfg = ocfg; extra_mrs_en = extra; lock_delay = ldly;
        if (ocfg) exp_q.push_back(EV_ODT_OFF * 256);
        exp_q.push_back(EV_CKE_LO * 256);
        exp_q.push_back(EV_DIV * 256 + int'(d));
        exp_q.push_back(EV_CKE_HI * 256);
        exp_q.push_back(EV_MRS * 256 + 0);
        if (ldly < 0) begin
            exp_q.push_back(EV_ERR * 256);
        end else begin
            if (extra) exp_q.push_back(EV_MRS * 256 + 1);
            exp_q.push_back(EV_DONE * 256);
        end
        offer(d);
    endtask

    task automatic run_reject(input logic [DIV_W-1:0] d, input bit ocfg);
        odt_en_cfg = ocfg;
        exp_q.push_back(EV_ERR * 256);
        offer(d);
        #1;
        check(!busy, "R2 stays idle", busy, 0);
        check(cke && odt == ocfg, "R2 cke/odt untouched", {cke, odt}, {1'b1, ocfg});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(cke && odt && !busy && req_ready && !done && !err && !mrs_req && !div_update,
              "R1 reset state", {cke, odt, busy, req_ready}, 4'b1101);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_change(8'd5, 1'b1, 1'b1, 10); settle("R8 extra on");
        run_change(8'd2, 1'b0, 1'b1, 3);  settle("R8 extra off at min");
        run_change(8'd8, 1'b1, 1'b0, 0);  settle("R1 max bound odt cfg off");
        run_reject(8'd9, 1'b1);           settle("R2 above max");
        run_reject(8'd1, 1'b0);           settle("R2 below min");
        run_change(8'd4, 1'b1, 1'b1, -1); settle("R10 lock timeout");
        run_change(8'd6, 1'b0, 1'b1, 20); settle("R10 recovery");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule